// File: doc/BRIEF.md
# Protected Page Write Buffer

This block sits behind a serial memory's bus interface and gathers the data bytes of one write transaction into a row-sized page latch. It keeps a valid bit for every slot of the latch. When the protocol logic signals a proper end of the transaction, it runs a timed write cycle that drives array write strobes for the loaded slots only. A write-control level can fence off the upper quarter of the array. The level counts only if it is seen high at some point in the window that runs from the transaction's start through the loading of the address.

The protocol front end gives four signals. It pulses `start_i` on every START. It pulses `addr_load_i` with the full byte address once both address bytes are in. It pulses `byte_vld_i` for each data byte it acknowledges. It then pulses either `commit_i` or `abort_i`. `commit_i` is for a STOP placed right after a data-byte acknowledge. `abort_i` is for a STOP placed anywhere else. While `busy_o` is high the block takes no command, which is how acknowledge polling sees the memory as busy. The write time is a clock-cycle count, so a short value can be used in simulation.

Top module: `prot_page_wbuf`

## Requirements
- R1: After reset `busy_o` and `mem_we_o` are low and no slot holds data.
- R2: The first byte after `addr_load_i` goes to the slot given by the low 5 address bits. Each later byte goes to the next slot. Every strobe in a cycle carries the row (address bits above bit 4) that was loaded.
- R3: The slot pointer wraps from 31 to 0 inside the same row. A byte that lands on a slot already loaded replaces the earlier data.
- R4: A commit drives one strobe for each loaded slot, and only for loaded slots. The strobes come in ascending slot order. The first one is in the cycle after the commit is sampled.
- R5: If `wc_i` is high in any cycle from the `start_i` cycle through the `addr_load_i` cycle, no strobe goes to an address whose two top bits are 2'b11 (0x1800 and up with 13 address bits). `busy_o` still runs for the full cycle.
- R6: With `wc_i` high, addresses below the top quarter are still written. A `wc_i` high that is seen only after the `addr_load_i` cycle does not block any write.
- R7: `abort_i` discards every loaded byte. A new `start_i` also discards every loaded byte. Neither one causes a strobe.
- R8: `busy_o` stays high for exactly `WR_CYCLES` cycles. While it is high, `start_i`, `addr_load_i`, `byte_vld_i`, `commit_i` and `abort_i` have no effect. The latch is empty when the cycle ends.
- R9: A commit while no slot is loaded does not start a cycle, and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START seen on the bus |
| addr_load_i | input | 1 | Both address bytes received |
| addr_i | input | AW | Byte address, sampled on `addr_load_i` |
| wc_i | input | 1 | Write-control level, high protects the top quarter |
| byte_vld_i | input | 1 | Data byte acknowledged |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | STOP right after a data-byte acknowledge |
| abort_i | input | 1 | STOP in any other slot |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | AW | Array write address |
| mem_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Write cycle in progress |

## Verification
Two cases are hard to reach from the ports.

The first is the protection window. The block has to catch a write-control pulse that lasts a single cycle and appears only on the START cycle. It also has to ignore a level that rises one cycle after the address is loaded. The stimulus drives `wc_i` separately in the start phase, the address phase and the data phase of each transaction, at top-quarter addresses.

The second is a slot loaded twice. To reach it, the stimulus starts a page near the row end and sends more than 32 bytes, so that the pointer wraps onto slots it has already filled. It also drives bytes, a START and a commit while a cycle is running. After that cycle ends, an empty commit shows that none of those commands were taken in.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned BYTE_W = 8;

  // upper quarter of the array: both top address bits set
  function automatic logic in_top_quarter(input logic [1:0] msb);
    return msb == 2'b11;
  endfunction
endpackage

// File: rtl/pwb_wp_track.sv
module pwb_wp_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic addr_load_i,
  input  logic wc_i,
  output logic prot_o
);
  logic addr_ph_q, prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_ph_q <= 1'b0;
      prot_q    <= 1'b0;
    end else begin
      if (start_i) begin
        addr_ph_q <= ~addr_load_i;
        prot_q    <= wc_i;
      end else if (addr_ph_q || addr_load_i) begin
        prot_q    <= prot_q | wc_i;
        if (addr_load_i) addr_ph_q <= 1'b0;
      end
    end
  end

  assign prot_o = prot_q;
endmodule

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int unsigned AW = 13,
  parameter int unsigned PG = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  addr_load_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  byte_vld_i,
  input  logic [7:0]            byte_i,
  input  logic [$clog2(PG)-1:0] rd_slot_i,
  output logic [AW-$clog2(PG)-1:0] row_o,
  output logic [PG-1:0]         mask_o,
  output logic [7:0]            rd_data_o
);
  localparam int unsigned OW = $clog2(PG);
  localparam int unsigned RW = AW - OW;

  logic [PG-1:0] mask_q;
  logic [OW-1:0] ptr_q;
  logic [RW-1:0] row_q;
  logic [7:0]    data_q [PG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ptr_q  <= '0;
      row_q  <= '0;
    end else begin
      if (clear_i)         mask_q <= '0;
      else if (byte_vld_i) mask_q[ptr_q] <= 1'b1;
      if (addr_load_i) begin
        ptr_q <= addr_i[OW-1:0];
        row_q <= addr_i[AW-1:OW];
      end else if (byte_vld_i) begin
        ptr_q <= ptr_q + 1'b1;   // wraps inside the row
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (byte_vld_i) data_q[ptr_q] <= byte_i;
  end

  assign row_o     = row_q;
  assign mask_o    = mask_q;
  assign rd_data_o = data_q[rd_slot_i];
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq #(
  parameter int unsigned PG        = 32,
  parameter int unsigned WR_CYCLES = 2000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  commit_i,
  input  logic                  any_i,
  output logic                  busy_o,
  output logic                  scan_o,
  output logic                  done_o,
  output logic [$clog2(PG)-1:0] slot_o
);
  localparam int unsigned OW = $clog2(PG);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);
  localparam logic [CW-1:0] SCAN = CW'(PG);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (commit_i && any_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign scan_o = busy_q && (cnt_q < SCAN);
  assign done_o = busy_q && (cnt_q == LAST);
  assign slot_o = cnt_q[OW-1:0];
endmodule

// File: rtl/prot_page_wbuf.sv
module prot_page_wbuf #(
  parameter int unsigned AW        = 13,
  parameter int unsigned PG        = 32,
  parameter int unsigned WR_CYCLES = 2000   // must be >= PG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wc_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          commit_i,
  input  logic          abort_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic          busy_o
);
  import pwb_pkg::*;

  localparam int unsigned OW = $clog2(PG);
  localparam int unsigned RW = AW - OW;

  logic          busy_w, scan_w, done_w, prot_w;
  logic [OW-1:0] slot_w;
  logic [RW-1:0] row_w;
  logic [PG-1:0] mask_w;
  logic [7:0]    rd_w;
  logic          start_g, load_g, byte_g, commit_g, clear_w;

  // commands are ignored while a write cycle runs
  assign start_g  = start_i     & ~busy_w;
  assign load_g   = addr_load_i & ~busy_w;
  assign byte_g   = byte_vld_i  & ~busy_w;
  assign commit_g = commit_i    & ~busy_w;
  assign clear_w  = ((start_i | abort_i) & ~busy_w) | done_w;

  pwb_wp_track u_wp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_g),
    .addr_load_i (load_g),
    .wc_i        (wc_i),
    .prot_o      (prot_w)
  );

  pwb_latch #(.AW(AW), .PG(PG)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_w),
    .addr_load_i (load_g),
    .addr_i      (addr_i),
    .byte_vld_i  (byte_g),
    .byte_i      (byte_i),
    .rd_slot_i   (slot_w),
    .row_o       (row_w),
    .mask_o      (mask_w),
    .rd_data_o   (rd_w)
  );

  pwb_seq #(.PG(PG), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_g),
    .any_i    (|mask_w),
    .busy_o   (busy_w),
    .scan_o   (scan_w),
    .done_o   (done_w),
    .slot_o   (slot_w)
  );

  assign mem_addr_o = {row_w, slot_w};
  assign mem_data_o = rd_w;
  assign mem_we_o   = scan_w && mask_w[slot_w]
                      && !(prot_w && in_top_quarter(row_w[RW-1 -: 2]));
  assign busy_o     = busy_w;
endmodule

// File: rtl/prot_page_wbuf_chk.sv
module prot_page_wbuf_chk #(
  parameter int unsigned AW        = 13,
  parameter int unsigned PG        = 32,
  parameter int unsigned WR_CYCLES = 2000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          commit_i,
  input logic          busy_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          prot_i,
  input logic [PG-1:0] mask_i
);
  localparam int unsigned OW = $clog2(PG);

  int unsigned bcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt_q <= 0;
    else if (busy_o) bcnt_q <= bcnt_q + 1;
    else             bcnt_q <= 0;
  end

  a_r8_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bcnt_q == WR_CYCLES);
  a_r8_busy_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt_q < WR_CYCLES);
  a_r4_we_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  a_r2_row_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[AW-1:OW]));
  a_r5_top_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[AW-1 -: 2] == 2'b11) |-> !prot_i);
  a_r9_empty_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_o && mask_i == '0) |=> !busy_o);
endmodule

bind prot_page_wbuf prot_page_wbuf_chk #(.AW(AW), .PG(PG), .WR_CYCLES(WR_CYCLES)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .prot_i     (prot_w),
  .mask_i     (mask_w)
);

// File: tb/prot_page_wbuf_tb_top.sv
`timescale 1ns/100ps
module prot_page_wbuf_tb_top;
  localparam int AW = 13;
  localparam int PG = 32;
  localparam int WR = 40;

  typedef struct packed {
    logic [12:0] a;
    logic        wc;
    logic [5:0]  n;
    logic [7:0]  s;
  } vec_t;

  // addr, wc in address phase, byte count, first data value
  localparam vec_t VEC [6] = '{
    '{13'h0040, 1'b0, 6'd4,  8'h10},
    '{13'h005E, 1'b0, 6'd5,  8'h20},
    '{13'h1FE0, 1'b1, 6'd3,  8'h30},
    '{13'h1805, 1'b0, 6'd2,  8'h40},
    '{13'h0123, 1'b1, 6'd3,  8'h50},
    '{13'h0007, 1'b0, 6'd34, 8'h60}
  };

  logic          clk = 0, rst_n = 0;
  logic          start_i = 0, addr_load_i = 0, wc_i = 0, byte_vld_i = 0;
  logic          commit_i = 0, abort_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    byte_i = '0;
  logic          mem_we_o, busy_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_data_o;

  int total = 0, bad = 0;
  logic [12:0] lg_a [64];
  logic [7:0]  lg_d [64];
  int lg_n = 0, bsy_n = 0;

  always #2.5 clk = ~clk;

  prot_page_wbuf #(.AW(AW), .PG(PG), .WR_CYCLES(WR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .wc_i(wc_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .commit_i(commit_i), .abort_i(abort_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .busy_o(busy_o));

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we_o && lg_n < 64) begin
        lg_a[lg_n] = mem_addr_o;
        lg_d[lg_n] = mem_data_o;
        lg_n++;
      end
      if (busy_o) bsy_n++;
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_txn(input logic [12:0] a, input logic wc_s, input logic wc_a,
                          input logic wc_l, input int n, input logic [7:0] sd);
    start_i = 1; wc_i = wc_s; step(); start_i = 0;
    wc_i = wc_a; addr_i = a; addr_load_i = 1; step(); addr_load_i = 0;
    wc_i = wc_l;
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1; byte_i = sd + 8'(i); step();
    end
    byte_vld_i = 0; wc_i = 0;
  endtask

  task automatic commit_run();
    lg_n = 0; bsy_n = 0;
    commit_i = 1; step(); commit_i = 0;
    repeat (WR + 4) step();
  endtask

  task automatic expect_page(input string rq, input logic [12:0] a, input int n,
                             input logic [7:0] sd, input logic blocked);
    logic [7:0] ed [PG];
    logic       ev [PG];
    int k = 0;
    for (int o = 0; o < PG; o++) begin ev[o] = 0; ed[o] = 0; end
    for (int i = 0; i < n; i++) begin
      ev[(int'(a[4:0]) + i) % PG] = 1;
      ed[(int'(a[4:0]) + i) % PG] = sd + 8'(i);
    end
    for (int o = 0; o < PG; o++) begin
      if (ev[o] && !blocked) begin
        if (k < lg_n) begin
          chk(rq, "wr addr", int'(lg_a[k]), int'({a[12:5], 5'(o)}));
          chk(rq, "wr data", int'(lg_d[k]), int'(ed[o]));
        end
        k++;
      end
    end
    chk(rq, "wr count", lg_n, k);
    chk("R8", "busy cycles", bsy_n, (n > 0) ? WR : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "busy at reset", int'(busy_o), 0);
    chk("R1", "we at reset", int'(mem_we_o), 0);
    rst_n = 1;
    step();
    // R1/R9 nothing loaded after reset: commit must not start a cycle
    commit_run();
    chk("R9", "empty commit busy", bsy_n, 0);
    chk("R1", "empty commit writes", lg_n, 0);

    // vector table: R2 R3 R4 R5 R6
    foreach (VEC[v]) begin
      load_txn(VEC[v].a, 1'b0, VEC[v].wc, 1'b0, int'(VEC[v].n), VEC[v].s);
      commit_run();
      expect_page("R2/R3/R4/R5/R6", VEC[v].a, int'(VEC[v].n), VEC[v].s,
                  VEC[v].wc && VEC[v].a >= 13'h1800);
    end

    // R5 wc high only in the start cycle still protects
    load_txn(13'h1A40, 1'b1, 1'b0, 1'b0, 3, 8'h70);
    commit_run();
    expect_page("R5", 13'h1A40, 3, 8'h70, 1'b1);

    // R6 wc rising after the address phase does not protect
    load_txn(13'h1A40, 1'b0, 1'b0, 1'b1, 3, 8'h80);
    commit_run();
    expect_page("R6", 13'h1A40, 3, 8'h80, 1'b0);

    // R7 abort discards loaded bytes
    load_txn(13'h0200, 1'b0, 1'b0, 1'b0, 3, 8'h90);
    abort_i = 1; step(); abort_i = 0;
    commit_run();
    chk("R7", "abort writes", lg_n, 0);
    chk("R7", "abort busy", bsy_n, 0);

    // R7 new start discards the previous transaction
    load_txn(13'h0200, 1'b0, 1'b0, 1'b0, 3, 8'hA0);
    load_txn(13'h0300, 1'b0, 1'b0, 1'b0, 1, 8'hB0);
    commit_run();
    expect_page("R7", 13'h0300, 1, 8'hB0, 1'b0);

    // R8 commands during busy are ignored
    load_txn(13'h0400, 1'b0, 1'b0, 1'b0, 2, 8'hC0);
    lg_n = 0; bsy_n = 0;
    commit_i = 1; step(); commit_i = 0;
    step();
    byte_vld_i = 1; byte_i = 8'hEE; step(); byte_vld_i = 0;
    start_i = 1; step(); start_i = 0;
    addr_i = 13'h0500; addr_load_i = 1; step(); addr_load_i = 0;
    commit_i = 1; step(); commit_i = 0;
    repeat (WR) step();
    expect_page("R8", 13'h0400, 2, 8'hC0, 1'b0);
    commit_run();
    chk("R8", "latch empty after cycle", bsy_n, 0);
    chk("R8", "no writes after cycle", lg_n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule